// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when a small 8-bit controller enters and leaves its two power-down modes. A request to stop pauses the processor and shuts down the main oscillator. A request to sleep pauses only the processor. While a mode is active, the block drives the main-oscillator enable, the crystal-pin pull-down, the processor clock gate and one clock enable for each peripheral group. The enables follow a fixed per-mode table. The timer group has an exception for event-counter mode during stop.

Leaving a mode depends on interrupt lines and on the enable bits that were latched when the mode was entered. Stop accepts a narrower set of wake sources than sleep. A stop exit restarts the main oscillator first. It then holds the processor frozen for a power-of-two number of always-on clock cycles, so that the oscillator can settle. A sleep exit resumes the processor on the next cycle. Every return to normal running is marked with a one-cycle wake-complete strobe.

The block runs entirely on the always-on low-frequency clock, and it produces only enable and gating levels.

Top module: `lowPowerSeq`

## Requirements
- R1: While reset is held low, and after it is released with no request pending, the block drives mainOscEn=1, xtalPinsLow=0, cpuClkEn=1, all four peripheral enables at 1 and wakeDone=0. Reset acts asynchronously, also from inside a power-down mode.
- R2: A stopReq sampled high in the running state leads, on the next cycle, to mainOscEn=0, xtalPinsLow=1, cpuClkEn=0, bitClkEn=0, watchClkEn=1 and lcdClkEn=1. When stopReq and sleepReq are high together, stop wins.
- R3: During stop and during the stabilization wait, tmrClkEn equals evtCntMode.
- R4: A sleepReq sampled high in the running state leads, on the next cycle, to cpuClkEn=0, with mainOscEn, bitClkEn, tmrClkEn, watchClkEn and lcdClkEn all at 1.
- R5: Interrupt bit map: bit 0 is the external interrupt, bit 1 the serial interface, bit 2 the watch timer and bit 3 the timer/event counter. Bits 4 to 7 are other sources. In stop, only bits 0 to 2 can wake the block. Bit 3 can also wake it, but only while evtCntMode=1.
- R6: In sleep, any interrupt bit whose latched enable is 1 wakes the block. The next cycle has cpuClkEn=1 and wakeDone=1, with no stabilization wait.
- R7: irqEn is latched in the cycle a mode is entered. A source whose latched enable is 0 never wakes the block, even if irqEn is raised later. A source whose latched enable is 1 still wakes it after irqEn is cleared.
- R8: A stop wake sets mainOscEn=1 and xtalPinsLow=0 on the next cycle. cpuClkEn then stays 0 for 2^STAB_LO_LOG cycles (stabSel=0) or 2^STAB_HI_LOG cycles (stabSel=1). stabSel is sampled in the stop-entry cycle.
- R9: wakeDone is high for exactly one cycle, the first cycle in which cpuClkEn is back at 1 after a wake.
- R10: stopReq and sleepReq are ignored while the stabilization wait runs. The processor resumes on schedule, and nothing is kept pending from those requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on low-frequency clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stopReq | input | 1 | Request to enter stop |
| sleepReq | input | 1 | Request to enter sleep |
| irqReq | input | IRQ_W | Interrupt request lines |
| irqEn | input | IRQ_W | Interrupt enable bits |
| stabSel | input | 1 | Stabilization length select (0 short, 1 long) |
| evtCntMode | input | 1 | Timer is counting an external event clock |
| mainOscEn | output | 1 | Main oscillator enable |
| xtalPinsLow | output | 1 | Pull both crystal pins low |
| cpuClkEn | output | 1 | Processor clock gate |
| bitClkEn | output | 1 | Basic interval timer clock enable |
| tmrClkEn | output | 1 | Timer/event counter clock enable |
| watchClkEn | output | 1 | Watch timer clock enable |
| lcdClkEn | output | 1 | LCD driver clock enable |
| wakeDone | output | 1 | One-cycle wake-complete strobe |

## Verification
The bench targets the timer wake source in stop. A design that ignored evtCntMode would either wake on a halted timer or miss a real event-counter wake.

It also probes the enable snapshot by changing irqEn after entry. A design that read irqEn live would wake on a source that was disabled at entry.

The stabilization length is checked on the exact cycle boundary with both settings, while stabSel toggles after entry. An off-by-one counter, or one that reads the select live, resumes a cycle early or late.

Finally, requests are held high throughout the wait. A design that latched them would fall straight back into stop after the wake.

// File: rtl/lpsPkg.sv
package lpsPkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STOP  = 2'd2,
    ST_STAB  = 2'd3
  } lpState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic snapLoad;   // latch enables and stabilization select
    logic cntClr;     // restart the stabilization counter
    logic cntRun;     // advance the stabilization counter
  } lpStrobe_t;
endpackage

// File: rtl/lpsDatapath.sv
module lpsDatapath
  import lpsPkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int TMR_IRQ = 3,
  parameter logic [IRQ_W-1:0] STOP_SRC_MASK = 8'h07,
  parameter int STAB_LO_LOG = 10,
  parameter int STAB_HI_LOG = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  lpStrobe_t        strobe,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic             stabSel,
  input  logic             evtCntMode,
  output logic             wakeStop,
  output logic             wakeSleep,
  output logic             stabDone
);
  localparam int CNT_W = STAB_HI_LOG;
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((1 << STAB_LO_LOG) - 1);
  localparam logic [CNT_W-1:0] LAST_HI = {CNT_W{1'b1}};

  logic [IRQ_W-1:0] enSnap;
  logic             selSnap;
  logic [IRQ_W-1:0] stopMask;
  logic [CNT_W-1:0] stabCnt;
  logic [CNT_W-1:0] stabLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSnap  <= '0;
      selSnap <= 1'b0;
    end else if (strobe.snapLoad) begin
      enSnap  <= irqEn;
      selSnap <= stabSel;
    end
  end

  // per-source stop qualification; the timer source depends on event mode
  for (genvar i = 0; i < IRQ_W; i++) begin : gMask
    if (i == TMR_IRQ) begin : gTmr
      assign stopMask[i] = evtCntMode;
    end else begin : gFix
      assign stopMask[i] = STOP_SRC_MASK[i];
    end
  end

  assign wakeSleep = |(irqReq & enSnap);
  assign wakeStop  = |(irqReq & enSnap & stopMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt <= '0;
    end else if (strobe.cntClr) begin
      stabCnt <= '0;
    end else if (strobe.cntRun) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  assign stabLast = selSnap ? LAST_HI : LAST_LO;
  assign stabDone = strobe.cntRun && (stabCnt == stabLast);
endmodule

// File: rtl/lpsCtrl.sv
module lpsCtrl
  import lpsPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopReq,
  input  logic      sleepReq,
  input  logic      wakeStop,
  input  logic      wakeSleep,
  input  logic      stabDone,
  input  logic      evtCntMode,
  output lpStrobe_t strobe,
  output logic      mainOscEn,
  output logic      xtalPinsLow,
  output logic      cpuClkEn,
  output logic      bitClkEn,
  output logic      tmrClkEn,
  output logic      watchClkEn,
  output logic      lcdClkEn,
  output logic      wakeDone
);
  lpState_t state, stateNext;
  logic     resume;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:   if (stopReq) stateNext = ST_STOP;
                else if (sleepReq) stateNext = ST_SLEEP;
      ST_SLEEP: if (wakeSleep) stateNext = ST_RUN;
      ST_STOP:  if (wakeStop) stateNext = ST_STAB;
      ST_STAB:  if (stabDone) stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  assign resume = ((state == ST_SLEEP) && wakeSleep) ||
                  ((state == ST_STAB) && stabDone);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_RUN;
      wakeDone <= 1'b0;
    end else begin
      state    <= stateNext;
      wakeDone <= resume;
    end
  end

  always_comb begin
    strobe.snapLoad = (state == ST_RUN) && (stopReq || sleepReq);
    strobe.cntClr   = (state == ST_STOP) && wakeStop;
    strobe.cntRun   = (state == ST_STAB);
  end

  always_comb begin
    mainOscEn   = 1'b1;
    xtalPinsLow = 1'b0;
    cpuClkEn    = 1'b1;
    bitClkEn    = 1'b1;
    tmrClkEn    = 1'b1;
    watchClkEn  = 1'b1;
    lcdClkEn    = 1'b1;
    case (state)
      ST_SLEEP: cpuClkEn = 1'b0;
      ST_STOP: begin
        mainOscEn   = 1'b0;
        xtalPinsLow = 1'b1;
        cpuClkEn    = 1'b0;
        bitClkEn    = 1'b0;
        tmrClkEn    = evtCntMode;
      end
      ST_STAB: begin
        cpuClkEn = 1'b0;
        bitClkEn = 1'b0;
        tmrClkEn = evtCntMode;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lowPowerSeq.sv
module lowPowerSeq
  import lpsPkg::*;
#(
  parameter int IRQ_W = 8,
  parameter int TMR_IRQ = 3,
  parameter logic [IRQ_W-1:0] STOP_SRC_MASK = 8'h07,
  parameter int STAB_LO_LOG = 10,
  parameter int STAB_HI_LOG = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stopReq,
  input  logic             sleepReq,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic             stabSel,
  input  logic             evtCntMode,
  output logic             mainOscEn,
  output logic             xtalPinsLow,
  output logic             cpuClkEn,
  output logic             bitClkEn,
  output logic             tmrClkEn,
  output logic             watchClkEn,
  output logic             lcdClkEn,
  output logic             wakeDone
);
  lpStrobe_t strobe;
  logic      wakeStop, wakeSleep, stabDone;

  lpsCtrl uCtrl (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .sleepReq(sleepReq),
    .wakeStop(wakeStop), .wakeSleep(wakeSleep), .stabDone(stabDone),
    .evtCntMode(evtCntMode), .strobe(strobe),
    .mainOscEn(mainOscEn), .xtalPinsLow(xtalPinsLow), .cpuClkEn(cpuClkEn),
    .bitClkEn(bitClkEn), .tmrClkEn(tmrClkEn), .watchClkEn(watchClkEn),
    .lcdClkEn(lcdClkEn), .wakeDone(wakeDone)
  );

  lpsDatapath #(
    .IRQ_W(IRQ_W), .TMR_IRQ(TMR_IRQ), .STOP_SRC_MASK(STOP_SRC_MASK),
    .STAB_LO_LOG(STAB_LO_LOG), .STAB_HI_LOG(STAB_HI_LOG)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .irqReq(irqReq), .irqEn(irqEn),
    .stabSel(stabSel), .evtCntMode(evtCntMode),
    .wakeStop(wakeStop), .wakeSleep(wakeSleep), .stabDone(stabDone)
  );
endmodule

// File: rtl/lpsChecker.sv
module lpsChecker (
  input logic clk,
  input logic rstN,
  input logic evtCntMode,
  input logic mainOscEn,
  input logic xtalPinsLow,
  input logic cpuClkEn,
  input logic bitClkEn,
  input logic tmrClkEn,
  input logic watchClkEn,
  input logic lcdClkEn,
  input logic wakeDone
);
  // R8
  osc_restart_cpu_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mainOscEn) |-> !cpuClkEn);
  // R2
  xtal_low_only_osc_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    xtalPinsLow |-> (!mainOscEn && !cpuClkEn && !bitClkEn));
  // R3
  tmr_follows_event_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mainOscEn) |-> (tmrClkEn == evtCntMode));
  // R2
  always_on_groups_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuClkEn |-> (watchClkEn && lcdClkEn));
  // R9
  wake_strobe_with_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |-> cpuClkEn);
  // R9
  wake_strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeDone |=> !wakeDone);
  // R9
  resume_marked_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuClkEn) |-> wakeDone);
endmodule

bind lowPowerSeq lpsChecker uChk (
  .clk(clk), .rstN(rstN), .evtCntMode(evtCntMode), .mainOscEn(mainOscEn),
  .xtalPinsLow(xtalPinsLow), .cpuClkEn(cpuClkEn), .bitClkEn(bitClkEn),
  .tmrClkEn(tmrClkEn), .watchClkEn(watchClkEn), .lcdClkEn(lcdClkEn),
  .wakeDone(wakeDone)
);

// File: tb/tb_lowPowerSeq.sv
`timescale 1ns/1ps
module tb_lowPowerSeq;
  localparam int LO = 10;
  localparam int HI = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReq = 1'b0, sleepReq = 1'b0, stabSel = 1'b0, evtCntMode = 1'b0;
  logic [7:0] irqReq = '0, irqEn = '0;
  logic mainOscEn, xtalPinsLow, cpuClkEn, bitClkEn, tmrClkEn, watchClkEn;
  logic lcdClkEn, wakeDone;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lowPowerSeq #(.STAB_LO_LOG(LO), .STAB_HI_LOG(HI)) dut (
    .clk(clk), .rstN(rstN), .stopReq(stopReq), .sleepReq(sleepReq),
    .irqReq(irqReq), .irqEn(irqEn), .stabSel(stabSel), .evtCntMode(evtCntMode),
    .mainOscEn(mainOscEn), .xtalPinsLow(xtalPinsLow), .cpuClkEn(cpuClkEn),
    .bitClkEn(bitClkEn), .tmrClkEn(tmrClkEn), .watchClkEn(watchClkEn),
    .lcdClkEn(lcdClkEn), .wakeDone(wakeDone)
  );

  // {isStop, evtCntMode, irqEn, irqReq, expectWake}
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'hFF, 8'h01, 1'b1},
    {1'b1, 1'b0, 8'hFF, 8'h02, 1'b1},
    {1'b1, 1'b0, 8'hFF, 8'h04, 1'b1},
    {1'b1, 1'b0, 8'hFF, 8'h08, 1'b0},
    {1'b1, 1'b1, 8'hFF, 8'h08, 1'b1},
    {1'b1, 1'b0, 8'hFF, 8'hF0, 1'b0},
    {1'b1, 1'b0, 8'hFE, 8'h01, 1'b0},
    {1'b1, 1'b1, 8'hF7, 8'h08, 1'b0},
    {1'b0, 1'b0, 8'hFF, 8'h80, 1'b1},
    {1'b0, 1'b0, 8'hFF, 8'h08, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'hFF, 1'b0},
    {1'b0, 1'b0, 8'h10, 8'h10, 1'b1}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; stopReq = 1'b0; sleepReq = 1'b0; irqReq = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // request at a negedge; returns at the negedge after the mode is entered
  task automatic enterMode(input logic isStop);
    @(negedge clk);
    if (isStop) stopReq = 1'b1; else sleepReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stopReq = 1'b0; sleepReq = 1'b0;
  endtask

  task automatic stabRun(input logic sel, input int cycles, input logic holdReq);
    doReset();
    stabSel = sel; irqEn = 8'h01;
    enterMode(1'b1);
    stabSel = ~sel;                       // R8: must be ignored after entry
    irqReq = 8'h01;
    @(posedge clk); @(negedge clk);
    irqReq = '0;
    chk(mainOscEn, 1, "R8 osc restarts at wake");
    chk(xtalPinsLow, 0, "R8 crystal pins released");
    chk(tmrClkEn, evtCntMode, "R3 timer during stabilization");
    if (holdReq) begin stopReq = 1'b1; sleepReq = 1'b1; end
    repeat (cycles - 1) @(posedge clk);
    @(negedge clk);
    chk(cpuClkEn, 0, "R8 cpu frozen on last wait cycle");
    @(posedge clk); @(negedge clk);
    chk(cpuClkEn, 1, "R8 cpu resumes after wait");
    chk(wakeDone, 1, "R9 strobe at resume");
    stopReq = 1'b0; sleepReq = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(wakeDone, 0, "R9 strobe is one cycle");
    if (holdReq) chk(cpuClkEn, 1, "R10 requests during wait not kept");
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #1;
    // R1: asynchronous reset state
    chk({mainOscEn, xtalPinsLow, cpuClkEn, bitClkEn, tmrClkEn, watchClkEn, lcdClkEn, wakeDone},
        8'b1011_1110, "R1 state under reset");
    doReset();
    @(negedge clk);
    chk({mainOscEn, xtalPinsLow, cpuClkEn, bitClkEn, tmrClkEn, watchClkEn, lcdClkEn, wakeDone},
        8'b1011_1110, "R1 state after reset");

    for (int v = 0; v < NV; v++) begin
      logic isStop, evt, exp;
      logic [7:0] en, req;
      {isStop, evt, en, req, exp} = VEC[v];
      doReset();
      evtCntMode = evt; irqEn = en;
      enterMode(isStop);
      if (isStop) begin
        chk({mainOscEn, xtalPinsLow, cpuClkEn, bitClkEn, watchClkEn, lcdClkEn},
            6'b010011, "R2 stop gating");
        chk(tmrClkEn, evt, "R3 timer in stop");
      end else begin
        chk({mainOscEn, cpuClkEn, bitClkEn, tmrClkEn, watchClkEn, lcdClkEn},
            6'b101111, "R4 sleep gating");
      end
      irqReq = req;
      @(posedge clk); @(negedge clk);
      if (isStop) chk(mainOscEn, exp, "R5 stop wake source");
      else begin
        chk(cpuClkEn, exp, "R6 sleep wake");
        chk(wakeDone, exp, "R6 sleep wake strobe");
      end
      irqReq = '0;
    end
    evtCntMode = 1'b0;

    // R2: stop wins when both requests arrive together
    doReset();
    @(negedge clk); stopReq = 1'b1; sleepReq = 1'b1;
    @(posedge clk); @(negedge clk); stopReq = 1'b0; sleepReq = 1'b0;
    chk(mainOscEn, 0, "R2 stop has priority");

    // R7: enable changes after entry
    doReset();
    irqEn = 8'h01;
    enterMode(1'b1);
    irqEn = 8'hFF; irqReq = 8'h02;
    @(posedge clk); @(negedge clk);
    chk(mainOscEn, 0, "R7 late enable ignored");
    irqEn = 8'h00; irqReq = 8'h01;
    @(posedge clk); @(negedge clk);
    irqReq = '0;
    chk(mainOscEn, 1, "R7 latched enable still wakes");

    // R1: reset from inside stop acts at once
    doReset();
    irqEn = '0;
    enterMode(1'b1);
    rstN = 1'b0; #1;
    chk({mainOscEn, cpuClkEn, xtalPinsLow}, 3'b110, "R1 async reset from stop");
    rstN = 1'b1;

    // R8, R9: both stabilization lengths; R10 with requests held
    stabRun(1'b0, 1 << LO, 1'b0);
    evtCntMode = 1'b1;
    stabRun(1'b1, 1 << HI, 1'b1);
    evtCntMode = 1'b0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule